// File: doc/BRIEF.md
# Chained Two-Level Interrupt Controller

This block collects single-cycle event pulses from two groups of sources and turns them into one interrupt request line for a host. Each group has its own 16-bit status register and its own 16-bit mask register. A pulse on an event input sets the matching status bit only if the matching mask bit is 1. Once set, the bit stays set until the host reads that status register. The read returns the contents and clears them.

The second status register is the host's entry point. Its top bit is not latched. It is a live flag that is 1 whenever any bit of the first status register is set. The host reads the second register first, handles the events it shows, and reads the first register only when the top bit is set. The interrupt line is the OR of the second register's bits after the second mask is applied. The top bit is included, so the second mask's top bit decides whether activity in the first register reaches the host.

Register selection uses a 2-bit address: 0 = first status, 1 = second status, 2 = first mask, 3 = second mask. Read data is combinational from the address while the read strobe is high. A status clear caused by a read takes effect at the clock edge that ends the read cycle.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is 0.
- R2: An event pulse sets a status bit only when the matching mask bit is 1. If the mask bit is 0, the pulse is discarded and does not appear in any later read.
- R3: A latched status bit stays set across idle cycles and further events. It is cleared only by a read of its own register.
- R4: A read of a status register (address 0 or 1) returns its current contents. The latched bits are 0 from the next cycle on.
- R5: An event that arrives in the same cycle as a read of its status register is not part of that read's data. It is returned by the next read of that register.
- R6: Bit 15 of the second status register (address 1) reads 1 exactly while the first status register is non-zero. Reading address 1 does not clear it. It falls to 0 in the cycle after the first status register is read empty.
- R7: Event input `ev2[15]` has no effect: bit 15 can only come from the summary.
- R8: `irq` is 1 exactly when some bit of the address-1 view, including the summary bit 15, is 1 while the same bit of the second mask is 1.
- R9: Mask registers (addresses 2 and 3) read back the last value written. Writes to addresses 0 and 1 have no effect.
- R10: Changing a mask does not alter bits that are already latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev1 | input | 16 | Event pulses for the first status register |
| ev2 | input | 16 | Event pulses for the second status register (bit 15 ignored) |
| host_addr | input | 2 | Register select: 0 stat1, 1 stat2, 2 mask1, 3 mask2 |
| host_rd | input | 1 | Read strobe; clears the selected status register at the clock edge |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data (0 when `host_rd` is low) |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that:
- a latched first-level bit survives any cycle without a read;
- no new bit appears where the mask was 0;
- a read with no coinciding event empties the register;
- `irq` cannot be high while the second mask is all zero;
- pending first-level events, with the summary bit unmasked, always raise `irq`;
- reading the second register leaves the summary bit standing.

Only the bench scenarios show the following:
- the read data values themselves;
- the hand-off of an event that coincides with a read into the next read;
- the discarding of `ev2[15]`;
- mask read-back and ignored status writes;
- the behaviour of latched bits once their mask is withdrawn.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

  typedef enum logic [1:0] {
    SEL_STAT1 = 2'd0,
    SEL_STAT2 = 2'd1,
    SEL_MASK1 = 2'd2,
    SEL_MASK2 = 2'd3
  } reg_sel_e;

  // Next value of a sticky status word: wiped by a read, then fresh unmasked events
  function automatic logic [15:0] latch_next(input logic [15:0] cur,
                                             input logic [15:0] ev,
                                             input logic [15:0] msk,
                                             input logic        clr);
    logic [15:0] kept;
    kept = clr ? '0 : cur;
    return kept | (ev & msk);
  endfunction

  // Request when any visible bit is enabled
  function automatic logic any_enabled(input logic [15:0] view,
                                       input logic [15:0] msk);
    return |(view & msk);
  endfunction

endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
  import irq_chain_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic [W-1:0] msk,
  input  logic         clr,
  output logic [W-1:0] stat
);

  logic [15:0] nxt;

  always_comb begin
    nxt = latch_next(16'(stat), 16'(ev), 16'(msk), clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= nxt[W-1:0];
  end

endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
  import irq_chain_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         rd,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] stat1,
  input  logic [W-1:0] stat2_view,
  output logic [W-1:0] mask1,
  output logic [W-1:0] mask2,
  output logic [W-1:0] rdata
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask1 <= '0;
      mask2 <= '0;
    end else if (wr) begin
      if (sel == SEL_MASK1) mask1 <= wdata;
      if (sel == SEL_MASK2) mask2 <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (sel)
        SEL_STAT1: rdata = stat1;
        SEL_STAT2: rdata = stat2_view;
        SEL_MASK1: rdata = mask1;
        default:   rdata = mask2;
      endcase
    end
  end

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev1,
  input  logic [W-1:0] ev2,
  input  logic [1:0]   host_addr,
  input  logic         host_rd,
  input  logic         host_wr,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  output logic         irq
);

  localparam int          SUM_POS  = W - 1;
  localparam logic [W-1:0] SUM_MASK = W'(1) << SUM_POS;

  // Named internal events, visible to the checker
  logic         rd_clr1, rd_clr2, sum_bit;
  logic [W-1:0] mask1, mask2, stat1, stat2_raw, stat2_view, ev2_kept;

  assign rd_clr1  = host_rd && (host_addr == SEL_STAT1);
  assign rd_clr2  = host_rd && (host_addr == SEL_STAT2);
  assign ev2_kept = ev2 & ~SUM_MASK;

  irq_stat_bank #(.W(W)) u_bank1 (
    .clk(clk), .rst_n(rst_n), .ev(ev1), .msk(mask1), .clr(rd_clr1), .stat(stat1)
  );

  irq_stat_bank #(.W(W)) u_bank2 (
    .clk(clk), .rst_n(rst_n), .ev(ev2_kept), .msk(mask2), .clr(rd_clr2), .stat(stat2_raw)
  );

  assign sum_bit    = |stat1;
  assign stat2_view = (stat2_raw & ~SUM_MASK) | (sum_bit ? SUM_MASK : '0);

  irq_host_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(host_addr), .rd(host_rd), .wr(host_wr),
    .wdata(host_wdata), .stat1(stat1), .stat2_view(stat2_view),
    .mask1(mask1), .mask2(mask2), .rdata(host_rdata)
  );

  always_comb begin
    irq = any_enabled(16'(stat2_view), 16'(mask2));
  end

endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ev1,
  input logic [W-1:0] mask1,
  input logic [W-1:0] mask2,
  input logic [W-1:0] stat1,
  input logic [W-1:0] stat2_view,
  input logic         rd_clr1,
  input logic         rd_clr2,
  input logic         irq
);

  // R3
  stat1_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr1 |=> (($past(stat1) & ~stat1) == '0));

  // R2
  stat1_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat1 & ~$past(stat1) & ~$past(mask1)) == '0));

  // R4
  clr1_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr1 && ((ev1 & mask1) == '0)) |=> (stat1 == '0));

  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask2 != '0));

  // R8
  summary_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat1 != '0) && mask2[W-1]) |-> irq);

  // R6
  summary_survives_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr2 && !rd_clr1 && (stat1 != '0)) |=> stat2_view[W-1]);

endmodule

bind irq_chain_ctrl irq_chain_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev1(ev1), .mask1(mask1), .mask2(mask2),
  .stat1(stat1), .stat2_view(stat2_view), .rd_clr1(rd_clr1),
  .rd_clr2(rd_clr2), .irq(irq)
);

// File: tb/test_irq_chain_ctrl.sv
`timescale 1ns/1ps
module test_irq_chain_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev1 = '0, ev2 = '0, host_wdata = '0;
  logic [1:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [15:0] host_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_chain_ctrl i_irq_chain_ctrl (
    .clk(clk), .rst_n(rst_n), .ev1(ev1), .ev2(ev2), .host_addr(host_addr),
    .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    host_addr = a; host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] e1, input logic [15:0] e2);
    ev1 = e1; ev2 = e2;
    @(negedge clk); ev1 = '0; ev2 = '0;
  endtask

  task automatic drain();
    logic [15:0] v;
    rd(2'd0, v); rd(2'd1, v);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 irq", {15'd0, irq}, 16'd0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 reg", v, 16'd0);
    end
  endtask

  task automatic t_mask_filter();
    logic [15:0] v;
    wr(2'd2, 16'h00F0);
    pulse(16'h0FFF, 16'h0000);
    rd(2'd0, v); check("R2 masked filter", v, 16'h00F0);
    rd(2'd0, v); check("R4 cleared after read", v, 16'h0000);
    wr(2'd3, 16'h000C);
    pulse(16'h0000, 16'h000F);
    rd(2'd1, v); check("R2 reg2 filter", v, 16'h000C);
    rd(2'd1, v); check("R4 reg2 cleared", v, 16'h0000);
    wr(2'd3, 16'h0000);
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    wr(2'd2, 16'hFFFF);
    pulse(16'h0010, 16'h0000);
    repeat (5) @(negedge clk);
    pulse(16'h0020, 16'h0000);
    rd(2'd0, v); check("R3 sticky", v, 16'h0030);
  endtask

  task automatic t_same_cycle();
    logic [15:0] v;
    pulse(16'h0040, 16'h0000);
    ev1 = 16'h0080;
    rd(2'd0, v);
    ev1 = '0;
    check("R5 read excludes coincident event", v, 16'h0040);
    rd(2'd0, v); check("R5 coincident event kept", v, 16'h0080);
  endtask

  task automatic t_summary();
    logic [15:0] v;
    pulse(16'h0001, 16'h0000);
    rd(2'd1, v); check("R6 summary set", v, 16'h8000);
    rd(2'd1, v); check("R6 summary survives reg2 read", v, 16'h8000);
    rd(2'd0, v); check("R6 reg1 content", v, 16'h0001);
    rd(2'd1, v); check("R6 summary cleared", v, 16'h0000);
  endtask

  task automatic t_ev2_top();
    logic [15:0] v;
    wr(2'd3, 16'hFFFF);
    pulse(16'h0000, 16'h8000);
    check("R7 irq unaffected", {15'd0, irq}, 16'd0);
    rd(2'd1, v); check("R7 ev2 bit15 ignored", v, 16'h0000);
  endtask

  task automatic t_irq();
    logic [15:0] v;
    wr(2'd3, 16'h8001);
    pulse(16'h0100, 16'h0000);
    check("R8 irq from summary", {15'd0, irq}, 16'd1);
    wr(2'd3, 16'h0001);
    check("R8 summary masked", {15'd0, irq}, 16'd0);
    rd(2'd0, v);
    pulse(16'h0000, 16'h0001);
    check("R8 irq from reg2 bit0", {15'd0, irq}, 16'd1);
    wr(2'd3, 16'h0002);
    check("R8 bit0 masked off", {15'd0, irq}, 16'd0);
    rd(2'd1, v); check("R10 latched bit kept after mask change", v, 16'h0001);
    check("R8 irq low after clear", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(2'd2, 16'hA5A5);
    rd(2'd2, v); check("R9 mask1 readback", v, 16'hA5A5);
    wr(2'd3, 16'h5A5A);
    rd(2'd3, v); check("R9 mask2 readback", v, 16'h5A5A);
    wr(2'd0, 16'hFFFF);
    wr(2'd1, 16'h7FFF);
    rd(2'd0, v); check("R9 stat1 write ignored", v, 16'h0000);
    rd(2'd1, v); check("R9 stat2 write ignored", v, 16'h0000);
  endtask

  task automatic t_mask_change();
    logic [15:0] v;
    wr(2'd2, 16'h0200);
    pulse(16'h0200, 16'h0000);
    wr(2'd2, 16'h0000);
    repeat (2) @(negedge clk);
    rd(2'd0, v); check("R10 latched bit survives unmask", v, 16'h0200);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_filter();
    t_sticky();
    t_same_cycle();
    t_summary();
    t_ev2_top();
    drain();
    t_irq();
    drain();
    t_regs();
    t_mask_change();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule